// File: doc/BRIEF.md
# Device ID risk matcher

This block decides whether an external serial RAM needs a workaround mode. The block takes the 64-bit device identifier one byte at a time and derives a 32-bit check key from it. It then looks the key up in a constant, ascending table of 58 known at-risk keys. The lookup is a binary search that runs over several clock cycles, so the block needs only one table read and one magnitude compare per cycle.

A controller pulses `start_i` and sets the size class of the device. It then delivers the eight identifier bytes on `byte_vld_i`/`byte_i` as they come off the already deserialised read. The block raises `busy_o` for the whole job and pulses `done_o` once. `match_o` carries the verdict until the next accepted start. A device whose size class is not 64 Mbit is never reported as at risk.

Top module: `idrisk_matcher`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `match_o` are all low.
- R2: The bytes accepted after a start fill the identifier from bit 0 upward. Byte k lands in bits 8k+7..8k, so the first four bytes form the low 32-bit word and the last four form the high word.
- R3: The check key is identifier bits 47..16 with key bits 27..24 forced to zero. Identifier bits 43..40 therefore never affect the verdict.
- R4: A key equal to any table entry gives a match. This covers the smallest entry 0x0053B24A, the largest entry 0xF0BFB158 and entries in between.
- R5: A key absent from the table gives no match. This covers keys below the smallest entry, keys above the largest entry and keys adjacent to an entry.
- R6: `size_cls_i` is sampled on the accepted start, with 2'b00 for 16 Mbit, 2'b01 for 32 Mbit, 2'b10 for 64 Mbit and 2'b11 for other sizes. `match_o` can be high only if the sampled class was 2'b10.
- R7: `done_o` is high for exactly one cycle per job. `busy_o` is high from the cycle after an accepted start through the `done_o` cycle, and low in the cycle that follows.
- R8: `done_o` rises at most 10 cycles after the edge that accepts the eighth byte. At most 7 of those cycles are search probe cycles.
- R9: `match_o` changes only in the `done_o` cycle, or when an accepted start clears it to 0.
- R10: A start pulse while `busy_o` is high is ignored. Bytes beyond the eighth, and bytes presented while no job is active, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new job (accepted only when idle) |
| byte_vld_i | input | 1 | Identifier byte valid |
| byte_i | input | 8 | Identifier byte, least significant first |
| size_cls_i | input | 2 | Device size class (2'b10 = 64 Mbit) |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle end-of-job pulse |
| match_o | output | 1 | Device is at risk (held until next start) |

## Verification
The hardest cases to reach from the ports are the two ends of the search. A key above the largest entry drives the low bound past the last index. A key below the smallest entry drives the high bound down to minus one, where a narrow unsigned index would wrap. The stimulus reaches both ends with identifiers chosen so that the extracted key is all ones or zero. It also includes identifiers whose masked nibble is non-zero, so the masking and the search bounds are both exercised through nothing but the byte stream.

// File: rtl/idrisk_pkg.sv
package idrisk_pkg;

    localparam int BYTE_W    = 8;
    localparam int ID_BYTES  = 8;
    localparam int ID_W      = BYTE_W * ID_BYTES;
    localparam int KEY_W     = 32;
    localparam int KEY_SHIFT = 16;
    localparam logic [KEY_W-1:0] KEY_MASK = 32'hF0FF_FFFF;
    localparam int TBL_N     = 58;
    localparam int IDX_W     = $clog2(TBL_N);
    // two extra bits: sign for hi = -1 and headroom for lo + hi
    localparam int BND_W     = IDX_W + 2;
    localparam int PROBE_MAX = IDX_W + 1;

    typedef enum logic [1:0] {
        SZ_16M   = 2'b00,
        SZ_32M   = 2'b01,
        SZ_64M   = 2'b10,
        SZ_OTHER = 2'b11
    } size_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CAPT,
        ST_SRCH,
        ST_FIN
    } ctl_st_e;

    typedef logic signed [BND_W-1:0] bound_t;

    typedef struct packed {
        bound_t lo;
        bound_t hi;
    } window_t;

    // ascending order is required by the search
    localparam logic [KEY_W-1:0] RISK_KEYS [TBL_N] = '{
        32'h0053B24A, 32'h0064A246, 32'h00B9A046, 32'h00BAA046, 32'h00C0A046,
        32'h1053B24A, 32'h1064A246, 32'h10B9A046, 32'h10BAA046, 32'h10C0A046,
        32'h2022A146, 32'h20A8A146, 32'h20C0A046, 32'h20C0B158, 32'h3022A146,
        32'h30A8A146, 32'h30C0A046, 32'h30C0B158, 32'h4026A158, 32'h402AA046,
        32'h402FA046, 32'h402FA048, 32'h4064A246, 32'h40A8A15A, 32'h40B9D14A,
        32'h5026A158, 32'h502AA046, 32'h502FA046, 32'h5064A246, 32'h50A8A15A,
        32'h50B9D14A, 32'h50C0A046, 32'h602AA046, 32'h6064A246, 32'h702AA046,
        32'h7064A246, 32'h8026A146, 32'h9026A146, 32'hA02FA046, 32'hB02FA046,
        32'hC003B246, 32'hC003B248, 32'hC091D14A, 32'hC0B8A046, 32'hC0BFB148,
        32'hD091D14A, 32'hD0B8A046, 32'hD0BFB148, 32'hE021A146, 32'hE0B8A046,
        32'hE0B9A046, 32'hE0BFA046, 32'hE0BFB158, 32'hF021A146, 32'hF0B8A046,
        32'hF0B9A046, 32'hF0BFA046, 32'hF0BFB158
    };

    function automatic logic [KEY_W-1:0] key_of(input logic [ID_W-1:0] id);
        logic [ID_W-1:0] sh;
        sh = id >> KEY_SHIFT;
        return sh[KEY_W-1:0] & KEY_MASK;
    endfunction

endpackage

// File: rtl/idrisk_capture.sv
module idrisk_capture #(
    parameter int BYTES = 8,
    parameter int BW    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_i,
    input  logic                en_i,
    input  logic                vld_i,
    input  logic [BW-1:0]       byte_i,
    output logic [BYTES*BW-1:0] id_o,
    output logic                full_o
);
    localparam int CW = $clog2(BYTES + 1);

    logic [CW-1:0]       cnt_q;
    logic [BYTES*BW-1:0] id_q;

    assign full_o = (cnt_q == CW'(BYTES));
    assign id_o   = id_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
            id_q  <= '0;
        end else if (en_i && vld_i && !full_o) begin
            id_q[cnt_q*BW +: BW] <= byte_i;
            cnt_q                <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/idrisk_search.sv
module idrisk_search
    import idrisk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    input  logic [KEY_W-1:0] key_i,
    output logic             fin_o,
    output logic             hit_o,
    output logic             act_o
);
    window_t          win_q;
    logic [KEY_W-1:0] key_q;
    logic             act_q;
    logic             fin_q;
    logic             hit_q;
    bound_t           sum;
    bound_t           mid;
    logic [KEY_W-1:0] probe;
    logic             empty;

    always_comb begin
        sum   = win_q.lo + win_q.hi;
        mid   = sum >>> 1;
        probe = RISK_KEYS[mid[IDX_W-1:0]];
        empty = (win_q.lo > win_q.hi);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
            key_q <= '0;
            act_q <= 1'b0;
            fin_q <= 1'b0;
            hit_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (go_i) begin
                win_q.lo <= '0;
                win_q.hi <= bound_t'(TBL_N - 1);
                key_q    <= key_i;
                act_q    <= 1'b1;
                hit_q    <= 1'b0;
            end else if (act_q) begin
                if (empty) begin
                    act_q <= 1'b0;
                    fin_q <= 1'b1;
                end else if (probe == key_q) begin
                    hit_q <= 1'b1;
                    act_q <= 1'b0;
                    fin_q <= 1'b1;
                end else if (key_q < probe) begin
                    win_q.hi <= mid - bound_t'(1);
                end else begin
                    win_q.lo <= mid + bound_t'(1);
                end
            end
        end
    end

    assign fin_o = fin_q;
    assign hit_o = hit_q;
    assign act_o = act_q;
endmodule

// File: rtl/idrisk_matcher.sv
module idrisk_matcher
    import idrisk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        byte_vld_i,
    input  logic [7:0]  byte_i,
    input  logic [1:0]  size_cls_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        match_o
);
    ctl_st_e          st_q;
    size_cls_e        size_q;
    logic             match_q;
    logic             accept;
    logic             go;
    logic             cap_full;
    logic [ID_W-1:0]  cap_id;
    logic             eng_fin;
    logic             eng_hit;
    logic             eng_act;

    assign accept = (st_q == ST_IDLE) && start_i;
    assign go     = (st_q == ST_CAPT) && cap_full;

    idrisk_capture #(.BYTES(ID_BYTES), .BW(BYTE_W)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (accept),
        .en_i   (st_q == ST_CAPT),
        .vld_i  (byte_vld_i),
        .byte_i (byte_i),
        .id_o   (cap_id),
        .full_o (cap_full)
    );

    idrisk_search u_eng (
        .clk   (clk),
        .rst   (rst),
        .go_i  (go),
        .key_i (key_of(cap_id)),
        .fin_o (eng_fin),
        .hit_o (eng_hit),
        .act_o (eng_act)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            size_q  <= SZ_16M;
            match_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start_i) begin
                    st_q    <= ST_CAPT;
                    size_q  <= size_cls_e'(size_cls_i);
                    match_q <= 1'b0;
                end
                ST_CAPT: if (cap_full) st_q <= ST_SRCH;
                ST_SRCH: if (eng_fin) begin
                    st_q    <= ST_FIN;
                    match_q <= eng_hit && (size_q == SZ_64M);
                end
                ST_FIN:  st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o  = (st_q != ST_IDLE);
    assign done_o  = (st_q == ST_FIN);
    assign match_o = match_q;
endmodule

// File: rtl/idrisk_matcher_chk.sv
module idrisk_matcher_chk
    import idrisk_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       match_o,
    input logic [1:0] size_q,
    input logic       srch_act
);
    logic [3:0] probe_cnt;

    always_ff @(posedge clk) begin
        if (rst || !srch_act) probe_cnt <= '0;
        else                  probe_cnt <= probe_cnt + 4'd1;
    end

    // R7
    done_one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7
    busy_at_done_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> busy_o);

    // R9
    match_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> (done_o || $stable(match_o)));

    // R6
    size_gate_chk: assert property (@(posedge clk) disable iff (rst)
        match_o |-> (size_q == SZ_64M));

    // R8
    probe_len_chk: assert property (@(posedge clk) disable iff (rst)
        srch_act |-> (probe_cnt < 4'(PROBE_MAX)));
endmodule

bind idrisk_matcher idrisk_matcher_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .match_o  (match_o),
    .size_q   (size_q),
    .srch_act (eng_act)
);

// File: tb/idrisk_matcher_bench.sv
module idrisk_matcher_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       byte_vld_i = 1'b0;
    logic [7:0] byte_i = '0;
    logic [1:0] size_cls_i = 2'b10;
    logic       busy_o, done_o, match_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    idrisk_matcher u_idrisk_matcher (
        .clk(clk), .rst(rst), .start_i(start_i), .byte_vld_i(byte_vld_i),
        .byte_i(byte_i), .size_cls_i(size_cls_i),
        .busy_o(busy_o), .done_o(done_o), .match_o(match_o)
    );

    localparam int NV = 12;
    localparam logic [63:0] V_ID [NV] = '{
        64'hABCD_0053_B24A_5D0D,  // R4 smallest entry
        64'h1234_0A53_B24A_5D0D,  // R3 masked nibble set
        64'h0000_F0BF_B158_0000,  // R4 largest entry
        64'h0000_F0BF_B158_0000,  // R6 32 Mbit
        64'hFFFF_5764_A246_1111,  // R3 R4 middle entry
        64'h0000_0000_0000_0000,  // R5 below smallest
        64'hFFFF_FFFF_FFFF_FFFF,  // R5 above largest
        64'h0000_0053_B24B_5D0D,  // R5 neighbour
        64'h0000_402F_A048_5D0D,  // R4 interior
        64'h0000_C003_B246_5D0D,  // R6 16 Mbit
        64'h0000_C003_B246_5D0D,  // R6 other size
        64'h5D0D_0000_0053_B24A   // R2 words swapped
    };
    localparam logic [1:0] V_SZ [NV] = '{
        2'b10, 2'b10, 2'b10, 2'b01, 2'b10, 2'b10,
        2'b10, 2'b10, 2'b10, 2'b00, 2'b11, 2'b10
    };
    localparam logic V_EXP [NV] = '{
        1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0,
        1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // start at a negedge; optional ignored start after byte 3
    task automatic run_job(input logic [63:0] id, input logic [1:0] sz,
                           input bit mid_start, output int lat);
        start_i = 1'b1; size_cls_i = sz;
        @(negedge clk); start_i = 1'b0;
        size_cls_i = ~sz;
        for (int b = 0; b < 8; b++) begin
            byte_vld_i = 1'b1; byte_i = id[b*8 +: 8];
            start_i = mid_start && (b == 3);
            @(negedge clk);
        end
        start_i = 1'b0;
        byte_vld_i = 1'b1; byte_i = 8'hFF;   // extra byte must be ignored
        lat = 0;
        while (!done_o && lat < 40) begin
            @(negedge clk); lat++;
            byte_vld_i = 1'b0;
        end
        byte_vld_i = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1
        check(!busy_o && !done_o && !match_o, "R1 reset", {busy_o, done_o, match_o}, 0);
        rst = 1'b0;
        // R10 bytes while idle: nothing starts
        byte_vld_i = 1'b1; byte_i = 8'h4A;
        repeat (3) @(negedge clk);
        byte_vld_i = 1'b0;
        check(!busy_o && !match_o, "R10 idle bytes", {busy_o, match_o}, 0);

        for (int v = 0; v < NV; v++) begin
            run_job(V_ID[v], V_SZ[v], 1'b0, lat);
            check(done_o == 1'b1, "R7 done reached", done_o, 1);
            check(lat <= 10, "R8 latency", lat, 10);
            check(match_o == V_EXP[v], "R2-R6 vector match", match_o, V_EXP[v]);
            check(busy_o == 1'b1, "R7 busy at done", busy_o, 1);
            @(negedge clk);
            check(!done_o && !busy_o, "R7 single pulse", {done_o, busy_o}, 0);
            check(match_o == V_EXP[v], "R9 hold", match_o, V_EXP[v]);
            @(negedge clk);
        end

        // R9 hold over idle time, then clear on start
        run_job(64'h0000_E0BF_B158_0000, 2'b10, 1'b0, lat);
        check(match_o == 1'b1, "R4 entry E0BFB158", match_o, 1);
        repeat (6) @(negedge clk);
        check(match_o == 1'b1, "R9 hold idle", match_o, 1);
        start_i = 1'b1; size_cls_i = 2'b10;
        @(negedge clk); start_i = 1'b0;
        check(match_o == 1'b0, "R9 clear on start", match_o, 0);
        check(busy_o == 1'b1, "R7 busy after start", busy_o, 1);
        for (int b = 0; b < 8; b++) begin
            byte_vld_i = 1'b1; byte_i = 8'h00; @(negedge clk);
        end
        byte_vld_i = 1'b0;
        while (busy_o) @(negedge clk);

        // R10 start while busy ignored
        run_job(64'h0000_1064_A246_0000, 2'b10, 1'b1, lat);
        check(done_o == 1'b1 && lat <= 10, "R10 start while busy", lat, 10);
        check(match_o == 1'b1, "R10 result intact", match_o, 1);
        @(negedge clk);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule